// File: doc/BRIEF.md
# SPI Interrupt Event and Enable Registers

This block keeps the sticky status flags of a serial peripheral interface controller and turns them into one interrupt request line. Single-cycle pulses from the controller set flags for five conditions: a transmit error, a received character dropped because no receive buffer was free, a finished transmit buffer, and a finished receive buffer. The fifth flag, a multimaster conflict, is detected inside the block. It is raised whenever the external select input is high while the controller runs as bus master.

Software reads the flag register and acknowledges flags by writing ones to them. A second, ordinary read/write register enables each flag as an interrupt source. The interrupt request is high while any flag is both set and enabled. Both registers are 8 bits wide and sit behind a small register port with a one-bit address.

Top module: `spi_evt_irq`

## Requirements
- R1: After reset, both registers read 0x00 and `irq` is low.
- R2: Each condition pulse sets its flag at the clock edge where it is sampled, and the flag stays set until it is cleared. The flags appear in the flag register (address 0) at these data bits: transmit error at bit 4, dropped receive character at bit 2, transmit buffer done at bit 1, receive buffer done at bit 0.
- R3: The conflict flag, data bit 5 of the flag register, is set at each clock edge where `extSel` and `masterMode` are both high. A high `extSel` while `masterMode` is low sets nothing.
- R4: A write to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: If a flag is being set and cleared in the same cycle, the set wins and the flag reads 1.
- R6: The enable register (address 1) holds the value last written to it. `irq` is high exactly when some flag bit and the enable bit at the same position are both 1. So `irq` stays high until every enabled set flag has been cleared or disabled.
- R7: Bits 7, 6 and 3 of both registers always read 0, and writes to them are ignored.
- R8: Reading either register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | Controller is operating as bus master |
| extSel | input | 1 | External select input, active high |
| txErrPulse | input | 1 | Transmit error pulse |
| rxDropPulse | input | 1 | Received character discarded, no buffer free |
| txDonePulse | input | 1 | Transmit buffer finished |
| rxDonePulse | input | 1 | Receive buffer finished |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = flags, 1 = enables |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag being set by hardware and acknowledged by software in the same clock cycle. The bench gets there by raising a condition pulse and the clear write in one drive slot, then reading the flag after the next edge. The conflict flag is also awkward, because it depends on two levels rather than a pulse. It is reached by holding `extSel` high, first with master mode off and then with it on, and checking after each edge. Interrupt persistence is covered with two enabled flags that are cleared one at a time.

// File: rtl/spi_evt_pkg.sv
`timescale 1ns/1ps
package spi_evt_pkg;
  localparam int REG_W = 8;
  // bit positions (software decodes these)
  localparam int B_MME = 5;
  localparam int B_TXE = 4;
  localparam int B_BSY = 2;
  localparam int B_TXB = 1;
  localparam int B_RXB = 0;
  localparam logic [REG_W-1:0] LIVE_BITS =
    (REG_W'(1) << B_MME) | (REG_W'(1) << B_TXE) | (REG_W'(1) << B_BSY) |
    (REG_W'(1) << B_TXB) | (REG_W'(1) << B_RXB);

  typedef struct packed {
    logic [REG_W-1:0] setVec;
    logic [REG_W-1:0] clrVec;
    logic             maskWe;
    logic [REG_W-1:0] maskVal;
  } evt_stb_t;
endpackage

// File: rtl/spi_evt_ctrl.sv
`timescale 1ns/1ps
module spi_evt_ctrl
  import spi_evt_pkg::*;
(
  input  logic             masterMode,
  input  logic             extSel,
  input  logic             txErrPulse,
  input  logic             rxDropPulse,
  input  logic             txDonePulse,
  input  logic             rxDonePulse,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWdata,
  output evt_stb_t         stb
);
  always_comb begin
    stb.setVec        = '0;
    stb.setVec[B_MME] = masterMode & extSel;
    stb.setVec[B_TXE] = txErrPulse;
    stb.setVec[B_BSY] = rxDropPulse;
    stb.setVec[B_TXB] = txDonePulse;
    stb.setVec[B_RXB] = rxDonePulse;
    stb.clrVec        = (regWe && !regAddr) ? (regWdata & LIVE_BITS) : '0;
    stb.maskWe        = regWe && regAddr;
    stb.maskVal       = regWdata & LIVE_BITS;
  end
endmodule

// File: rtl/spi_evt_dp.sv
`timescale 1ns/1ps
module spi_evt_dp
  import spi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evt_stb_t         stb,
  input  logic             regAddr,
  output logic [REG_W-1:0] evtQ,
  output logic [REG_W-1:0] maskQ,
  output logic [REG_W-1:0] regRdata,
  output logic             irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= '0;
    end else begin
      // set dominates a simultaneous clear
      evtQ <= (stb.setVec | (evtQ & ~stb.clrVec)) & LIVE_BITS;
      if (stb.maskWe) maskQ <= stb.maskVal;
    end
  end

  assign regRdata = regAddr ? maskQ : evtQ;
  assign irq      = |(evtQ & maskQ);
endmodule

// File: rtl/spi_evt_irq.sv
`timescale 1ns/1ps
module spi_evt_irq
  import spi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic             extSel,
  input  logic             txErrPulse,
  input  logic             rxDropPulse,
  input  logic             txDonePulse,
  input  logic             rxDonePulse,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             irq
);
  evt_stb_t         stb;
  logic [REG_W-1:0] evtQ;
  logic [REG_W-1:0] maskQ;

  spi_evt_ctrl u_ctrl (
    .masterMode (masterMode),
    .extSel     (extSel),
    .txErrPulse (txErrPulse),
    .rxDropPulse(rxDropPulse),
    .txDonePulse(txDonePulse),
    .rxDonePulse(rxDonePulse),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .stb        (stb)
  );

  spi_evt_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .regAddr (regAddr),
    .evtQ    (evtQ),
    .maskQ   (maskQ),
    .regRdata(regRdata),
    .irq     (irq)
  );
endmodule

// File: rtl/spi_evt_chk.sv
`timescale 1ns/1ps
module spi_evt_chk
  import spi_evt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             masterMode,
  input logic             extSel,
  input logic             txErrPulse,
  input logic             rxDropPulse,
  input logic             txDonePulse,
  input logic             rxDonePulse,
  input logic             regWe,
  input logic             regAddr,
  input logic [REG_W-1:0] regWdata,
  input logic             irq,
  input logic [REG_W-1:0] evtQ,
  input logic [REG_W-1:0] maskQ
);
  logic [REG_W-1:0] hwSet;
  logic [REG_W-1:0] swClr;
  always_comb begin
    hwSet        = '0;
    hwSet[B_MME] = masterMode & extSel;
    hwSet[B_TXE] = txErrPulse;
    hwSet[B_BSY] = rxDropPulse;
    hwSet[B_TXB] = txDonePulse;
    hwSet[B_RXB] = rxDonePulse;
    swClr        = (regWe && !regAddr) ? regWdata : '0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet != '0) |=> ((evtQ & $past(hwSet)) == $past(hwSet)));

  p_conflict_r3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && extSel) |=> evtQ[B_MME]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(evtQ) & ~$past(swClr)) & ~evtQ) == '0));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtQ & $past(swClr) & ~$past(hwSet)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((hwSet & swClr) != '0) |=> ((evtQ & $past(hwSet & swClr)) == $past(hwSet & swClr)));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((hwSet != '0) || (regWe && regAddr)));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((evtQ | maskQ) & ~LIVE_BITS) == '0);
endmodule

bind spi_evt_irq spi_evt_chk u_chk (.*);

// File: tb/spi_evt_irq_bench.sv
`timescale 1ns/1ps
module spi_evt_irq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterMode = 1'b0, extSel = 1'b0;
  logic       txErrPulse = 1'b0, rxDropPulse = 1'b0, txDonePulse = 1'b0, rxDonePulse = 1'b0;
  logic       regWe = 1'b0, regAddr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_evt_irq u_spi_evt_irq (.*);

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    step();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic wipe();
    wr(1'b0, 8'hFF); wr(1'b1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); check("R1 flags", v, 8'h00);
    rd(1'b1, v); check("R1 enables", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    wipe();
    txErrPulse = 1'b1; step(); txErrPulse = 1'b0;
    rd(1'b0, v); check("R2 txerr bit4", v, 8'h10);
    rxDropPulse = 1'b1; step(); rxDropPulse = 1'b0;
    rd(1'b0, v); check("R2 drop bit2", v, 8'h14);
    txDonePulse = 1'b1; rxDonePulse = 1'b1; step();
    txDonePulse = 1'b0; rxDonePulse = 1'b0;
    step();
    rd(1'b0, v); check("R2 done bits sticky", v, 8'h17);
    rd(1'b0, v); check("R8 reread unchanged", v, 8'h17);
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    wipe();
    masterMode = 1'b0; extSel = 1'b1; step();
    rd(1'b0, v); check("R3 slave no set", v, 8'h00);
    masterMode = 1'b1; step();
    extSel = 1'b0;
    rd(1'b0, v); check("R3 master sets bit5", v, 8'h20);
    masterMode = 1'b0;
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R3 cleared", v, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wipe();
    txDonePulse = 1'b1; rxDonePulse = 1'b1; step();
    txDonePulse = 1'b0; rxDonePulse = 1'b0;
    wr(1'b0, 8'h01);
    rd(1'b0, v); check("R4 clear one", v, 8'h02);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R4 zero write no effect", v, 8'h02);
    wr(1'b0, 8'h02);
    rd(1'b0, v); check("R4 clear last", v, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    wipe();
    txDonePulse = 1'b1; regAddr = 1'b0; regWdata = 8'h02; regWe = 1'b1;
    step();
    txDonePulse = 1'b0; regWe = 1'b0; regWdata = '0;
    rd(1'b0, v); check("R5 set beats clear", v, 8'h02);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wipe();
    wr(1'b1, 8'h02);
    rd(1'b1, v); check("R6 enable readback", v, 8'h02);
    rxDonePulse = 1'b1; step(); rxDonePulse = 1'b0;
    check("R6 masked source", {7'b0, irq}, 8'h00);
    txDonePulse = 1'b1; step(); txDonePulse = 1'b0;
    check("R6 enabled source", {7'b0, irq}, 8'h01);
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h02);
    check("R6 irq held by rx", {7'b0, irq}, 8'h01);
    wr(1'b0, 8'h01);
    check("R6 irq drops", {7'b0, irq}, 8'h00);
    rxDonePulse = 1'b1; step(); rxDonePulse = 1'b0;
    check("R6 irq again", {7'b0, irq}, 8'h01);
    wr(1'b1, 8'h00);
    check("R6 disabled", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wipe();
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R7 enable reserved", v, 8'h37);
    masterMode = 1'b1; extSel = 1'b1;
    txErrPulse = 1'b1; rxDropPulse = 1'b1; txDonePulse = 1'b1; rxDonePulse = 1'b1;
    step();
    masterMode = 1'b0; extSel = 1'b0;
    txErrPulse = 1'b0; rxDropPulse = 1'b0; txDonePulse = 1'b0; rxDonePulse = 1'b0;
    rd(1'b0, v); check("R7 flag reserved", v, 8'h37);
    wr(1'b0, 8'hC8);
    rd(1'b0, v); check("R7 reserved write ignored", v, 8'h37);
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    t_reset();
    rstN = 1'b1;
    step();
    t_reset();
    t_events();
    t_conflict();
    t_clear();
    t_set_wins();
    t_irq();
    t_reserved();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule